// File: doc/BRIEF.md
# Online Statistical Randomness Health Tester

This block watches a serial random bit stream, one bit per clock when `bit_valid` is high, and raises a separate one-cycle fail pulse for each statistical test that the stream does not pass. The pulses feed a neighbouring status block. Recovery is handled elsewhere.

Three tests work on fixed blocks of 20,000 accepted bits:
- the count of ones;
- a 4-bit pattern histogram, reduced to a sum-of-squares statistic;
- a histogram of run lengths, kept separately for each polarity.

Their verdicts appear together with a `block_done` pulse. After each verdict the block tests start again from zero.

Two streak detectors run without regard to block edges. One flags a run of 34 identical bits and the other a run of 48.

A separate port accepts full 128-bit output words. It flags any accepted word that equals the word accepted just before it.

All thresholds are elaboration-time parameters.

Top module: `rng_health_monitor`

## Requirements
- R1: After synchronous reset, every output (`block_done` and all six fail pulses) is low.
- R2: A block is BLOCK_BITS (default 20000, a multiple of 4) cycles with `bit_valid` high. Cycles with `bit_valid` low are ignored. `block_done` is high for exactly the one cycle after the clock edge that accepts the last bit of a block.
- R3: `fail_monobit` pulses with `block_done` when the number of ones in the block is not strictly greater than 9654 and strictly less than 10346.
- R4: The block is cut into 5000 non-overlapping 4-bit groups, starting at its first bit, and the occurrences of each of the 16 values are counted. `fail_poker` pulses with `block_done` when 16·Σcount² − 5000² is not strictly between 5150 and 287000.
- R5: Maximal runs inside a block are counted by polarity and length. The length classes are 1, 2, 3, 4, 5 and 6-or-more. A run open at the block end is closed there, and the next block starts a new run. `fail_runs` pulses with `block_done` when any of the 12 counts falls outside its inclusive interval. The intervals, the same for both polarities, are [2267,2733], [1079,1421], [502,748], [223,402], [90,223] and [90,223].
- R6: `fail_long_run` pulses for one cycle after the edge that accepts the 34th consecutive identical bit. It pulses at most once per run. Runs continue across block boundaries.
- R7: `fail_noise` pulses for one cycle after the edge that accepts the 48th consecutive identical bit. It pulses at most once per run. Runs continue across block boundaries.
- R8: `fail_repeat` pulses for one cycle after an edge with `word_valid` high whose `word_data` equals the previously accepted word. The first word after reset never fails. Data presented with `word_valid` low is neither compared nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial random bit |
| word_valid | input | 1 | Qualifies `word_data` this cycle |
| word_data | input | 128 | Output word for the repeat check |
| block_done | output | 1 | One-cycle pulse: block verdicts valid |
| fail_monobit | output | 1 | Ones-count failure pulse |
| fail_poker | output | 1 | 4-bit pattern statistic failure pulse |
| fail_runs | output | 1 | Run-length histogram failure pulse |
| fail_long_run | output | 1 | 34-bit streak pulse |
| fail_noise | output | 1 | 48-bit streak pulse |
| fail_repeat | output | 1 | Repeated output word pulse |

## Verification
A wrong bit index or a lost accepted bit shows first as `block_done` arriving in the wrong cycle, and that is visible within one block. A corrupted histogram or ones counter stays hidden until the end of the block. There it flips a verdict on a stream chosen to sit on the other side of the bound. For that reason the stimulus mixes pseudo-random, alternating and biased blocks. Streak length errors show within one cycle of the 34th or 48th bit. This is checked on runs of exactly 33, exactly 34 and 61 bits, and on a run that straddles a block edge.

// File: rtl/rht_pkg.sv
`timescale 1ns/1ps
package rht_pkg;
  localparam int RUN_BINS = 6;
  typedef int unsigned bound_arr_t [RUN_BINS];
  // inclusive interval per length class 1..5, 6+
  localparam bound_arr_t RUN_LO_DEF = '{2267, 1079, 502, 223, 90, 90};
  localparam bound_arr_t RUN_HI_DEF = '{2733, 1421, 748, 402, 223, 223};
endpackage

// File: rtl/rht_freq_test.sv
`timescale 1ns/1ps
module rht_freq_test #(
  parameter int BLOCK_BITS = 20000,
  parameter int MONO_LO    = 9654,
  parameter int MONO_HI    = 10346,
  parameter int POKER_LO   = 5150,
  parameter int POKER_HI   = 287000
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic blk_last,
  output logic fail_mono,
  output logic fail_poker
);
  localparam int NIBS = BLOCK_BITS / 4;
  localparam int CW   = $clog2(BLOCK_BITS + 1);
  localparam int PW   = $clog2(NIBS + 1);
  localparam int SW   = 2 * PW + 5;
  localparam logic [SW-1:0] NIB_SQ = SW'(NIBS) * SW'(NIBS);

  logic [CW-1:0] ones_q, ones_d;
  logic [2:0]    sh_q;
  logic [1:0]    ph_q;
  logic [PW-1:0] pk_q [16];
  logic [SW-1:0] sq_q, sq_d, stat;
  logic [3:0]    nib;
  logic          nib_done;

  // sum of squares kept incrementally: (c+1)^2 - c^2 = 2c+1
  always_comb begin
    ones_d   = ones_q + CW'(bit_in);
    nib      = {sh_q, bit_in};
    nib_done = (ph_q == 2'd3);
    sq_d     = sq_q;
    if (nib_done) sq_d = sq_q + SW'({pk_q[nib], 1'b1});
    stat = (sq_d << 4) - NIB_SQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q     <= '0;
      sh_q       <= '0;
      ph_q       <= '0;
      sq_q       <= '0;
      fail_mono  <= 1'b0;
      fail_poker <= 1'b0;
      for (int k = 0; k < 16; k++) pk_q[k] <= '0;
    end else begin
      fail_mono  <= 1'b0;
      fail_poker <= 1'b0;
      if (bit_valid) begin
        sh_q <= {sh_q[1:0], bit_in};
        ph_q <= ph_q + 2'd1;
        if (blk_last) begin
          ones_q     <= '0;
          sq_q       <= '0;
          ph_q       <= '0;
          for (int k = 0; k < 16; k++) pk_q[k] <= '0;
          fail_mono  <= !(ones_d > CW'(MONO_LO) && ones_d < CW'(MONO_HI));
          fail_poker <= !(stat > SW'(POKER_LO) && stat < SW'(POKER_HI));
        end else begin
          ones_q <= ones_d;
          sq_q   <= sq_d;
          if (nib_done) pk_q[nib] <= pk_q[nib] + PW'(1);
        end
      end
    end
  end

  p_mono_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    fail_mono |-> $past(bit_valid && blk_last));
  p_poker_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    fail_poker |-> $past(bit_valid && blk_last));
endmodule

// File: rtl/rht_run_test.sv
`timescale 1ns/1ps
module rht_run_test import rht_pkg::*; #(
  parameter int         BLOCK_BITS = 20000,
  parameter bound_arr_t RUN_LO     = RUN_LO_DEF,
  parameter bound_arr_t RUN_HI     = RUN_HI_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic blk_last,
  output logic fail_runs
);
  localparam int CW = $clog2(BLOCK_BITS + 1);
  localparam int LW = $clog2(RUN_BINS + 1);

  logic          prev_q, first_q;
  logic [LW-1:0] len_q, new_len, bin_a, bin_b;
  logic [CW-1:0] c0_q [RUN_BINS];
  logic [CW-1:0] c1_q [RUN_BINS];
  logic [CW-1:0] c0_d [RUN_BINS];
  logic [CW-1:0] c1_d [RUN_BINS];
  logic          cont, close_a, bad;

  // close_a: previous run ends on a change; blk_last: current run ends at block edge
  always_comb begin
    cont    = !first_q && (bit_in == prev_q);
    close_a = !first_q && (bit_in != prev_q);
    new_len = cont ? ((len_q == LW'(RUN_BINS)) ? len_q : len_q + LW'(1)) : LW'(1);
    bin_a   = len_q - LW'(1);
    bin_b   = new_len - LW'(1);
    bad     = 1'b0;
    for (int i = 0; i < RUN_BINS; i++) begin
      c0_d[i] = c0_q[i] + CW'(close_a && !prev_q && bin_a == LW'(i))
                        + CW'(blk_last && !bit_in && bin_b == LW'(i));
      c1_d[i] = c1_q[i] + CW'(close_a && prev_q && bin_a == LW'(i))
                        + CW'(blk_last && bit_in && bin_b == LW'(i));
      if (c0_d[i] < CW'(RUN_LO[i]) || c0_d[i] > CW'(RUN_HI[i]) ||
          c1_d[i] < CW'(RUN_LO[i]) || c1_d[i] > CW'(RUN_HI[i]))
        bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b0;
      first_q   <= 1'b1;
      len_q     <= '0;
      fail_runs <= 1'b0;
      for (int i = 0; i < RUN_BINS; i++) begin
        c0_q[i] <= '0;
        c1_q[i] <= '0;
      end
    end else begin
      fail_runs <= 1'b0;
      if (bit_valid) begin
        prev_q    <= bit_in;
        len_q     <= new_len;
        first_q   <= blk_last;
        fail_runs <= blk_last && bad;
        for (int i = 0; i < RUN_BINS; i++) begin
          c0_q[i] <= blk_last ? '0 : c0_d[i];
          c1_q[i] <= blk_last ? '0 : c1_d[i];
        end
      end
    end
  end

  p_runs_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    fail_runs |-> $past(bit_valid && blk_last));
  p_len_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    len_q <= LW'(RUN_BINS));
endmodule

// File: rtl/rht_streak_detect.sv
`timescale 1ns/1ps
module rht_streak_detect #(
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic fail_long,
  output logic fail_noise
);
  localparam int LW = $clog2(NOISE_RUN + 1);

  logic          started_q, prev_q, eq;
  logic [LW-1:0] len_q;

  assign eq = started_q && (bit_in == prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q  <= 1'b0;
      prev_q     <= 1'b0;
      len_q      <= '0;
      fail_long  <= 1'b0;
      fail_noise <= 1'b0;
    end else begin
      fail_long  <= 1'b0;
      fail_noise <= 1'b0;
      if (bit_valid) begin
        started_q  <= 1'b1;
        prev_q     <= bit_in;
        len_q      <= eq ? ((len_q == LW'(NOISE_RUN)) ? len_q : len_q + LW'(1)) : LW'(1);
        fail_long  <= eq && (len_q == LW'(LONG_RUN - 1));
        fail_noise <= eq && (len_q == LW'(NOISE_RUN - 1));
      end
    end
  end

  p_long_single_r6: assert property (@(posedge clk) disable iff (rst)
    fail_long |=> !fail_long);
  p_long_needs_bit_r6: assert property (@(posedge clk) disable iff (rst)
    fail_long |-> $past(bit_valid));
  p_noise_single_r7: assert property (@(posedge clk) disable iff (rst)
    fail_noise |=> !fail_noise);
endmodule

// File: rtl/rht_repeat_check.sv
`timescale 1ns/1ps
module rht_repeat_check #(
  parameter int WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              fail_repeat
);
  logic              have_q;
  logic [WORD_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q      <= 1'b0;
      prev_q      <= '0;
      fail_repeat <= 1'b0;
    end else begin
      fail_repeat <= 1'b0;
      if (word_valid) begin
        have_q      <= 1'b1;
        prev_q      <= word_data;
        fail_repeat <= have_q && (word_data == prev_q);
      end
    end
  end

  p_repeat_needs_word_r8: assert property (@(posedge clk) disable iff (rst)
    fail_repeat |-> $past(word_valid));
endmodule

// File: rtl/rng_health_monitor.sv
`timescale 1ns/1ps
module rng_health_monitor import rht_pkg::*; #(
  parameter int         BLOCK_BITS = 20000,
  parameter int         MONO_LO    = 9654,
  parameter int         MONO_HI    = 10346,
  parameter int         POKER_LO   = 5150,
  parameter int         POKER_HI   = 287000,
  parameter bound_arr_t RUN_LO     = RUN_LO_DEF,
  parameter bound_arr_t RUN_HI     = RUN_HI_DEF,
  parameter int         LONG_RUN   = 34,
  parameter int         NOISE_RUN  = 48,
  parameter int         WORD_W     = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              block_done,
  output logic              fail_monobit,
  output logic              fail_poker,
  output logic              fail_runs,
  output logic              fail_long_run,
  output logic              fail_noise,
  output logic              fail_repeat
);
  localparam int CW = $clog2(BLOCK_BITS + 1);

  logic [CW-1:0] idx_q;
  logic          blk_last;

  assign blk_last = (idx_q == CW'(BLOCK_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      block_done <= 1'b0;
    end else begin
      block_done <= bit_valid && blk_last;
      if (bit_valid) idx_q <= blk_last ? '0 : idx_q + CW'(1);
    end
  end

  rht_freq_test #(
    .BLOCK_BITS(BLOCK_BITS), .MONO_LO(MONO_LO), .MONO_HI(MONO_HI),
    .POKER_LO(POKER_LO), .POKER_HI(POKER_HI)
  ) u_freq (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .blk_last(blk_last), .fail_mono(fail_monobit), .fail_poker(fail_poker)
  );

  rht_run_test #(
    .BLOCK_BITS(BLOCK_BITS), .RUN_LO(RUN_LO), .RUN_HI(RUN_HI)
  ) u_runs (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .blk_last(blk_last), .fail_runs(fail_runs)
  );

  rht_streak_detect #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_streak (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .fail_long(fail_long_run), .fail_noise(fail_noise)
  );

  rht_repeat_check #(.WORD_W(WORD_W)) u_repeat (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .fail_repeat(fail_repeat)
  );

  p_idx_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    idx_q < CW'(BLOCK_BITS));
  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    block_done |=> !block_done);
  p_mono_with_done_r3: assert property (@(posedge clk) disable iff (rst)
    fail_monobit |-> block_done);
  p_runs_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    fail_runs |-> block_done);
endmodule

// File: tb/tb_rng_health_monitor.sv
`timescale 1ns/1ps
module tb_rng_health_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 20000;
  localparam int WATCHDOG = 190000;
  localparam int RLO [6] = '{2267, 1079, 502, 223, 90, 90};
  localparam int RHI [6] = '{2733, 1421, 748, 402, 223, 223};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0, bit_in = 1'b0, word_valid = 1'b0;
  logic [127:0] word_data = '0;
  logic block_done, fail_monobit, fail_poker, fail_runs;
  logic fail_long_run, fail_noise, fail_repeat;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_health_monitor dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .word_valid(word_valid), .word_data(word_data),
    .block_done(block_done), .fail_monobit(fail_monobit), .fail_poker(fail_poker),
    .fail_runs(fail_runs), .fail_long_run(fail_long_run), .fail_noise(fail_noise),
    .fail_repeat(fail_repeat)
  );

  typedef struct packed {
    logic done, mono, poker, runs, lng, noise, rep;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  int m_idx = 0, m_ones = 0, m_nib = 0, m_ph = 0;
  int m_pk [16];
  int m_r0 [6];
  int m_r1 [6];
  int m_cur_bit = 0, m_cur_len = 0;
  bit m_first = 1;
  int m_sprev = 0, m_slen = 0;
  bit m_sstart = 0;
  logic [127:0] m_wprev = '0;
  bit m_whave = 0;
  int cyc = 0, wn = 0;
  logic [127:0] wlast = '0;
  logic [31:0] lfsr = 32'hACE1_2461;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic lfsr_bit();
    lfsr = lfsr[0] ? ((lfsr >> 1) ^ 32'h8020_0003) : (lfsr >> 1);
    return lfsr[0];
  endfunction

  task automatic record_run(input int b, input int len);
    int bin = (len >= 6) ? 5 : len - 1;
    if (b != 0) m_r1[bin]++; else m_r0[bin]++;
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic step(input logic v, input logic b);
    exp_t e = '0;
    logic wv;
    logic [127:0] w;
    longint sumsq, stat;
    @(negedge clk);
    cyc++;
    wv = (cyc % 50 == 0);
    if (wv) begin
      wn++;
      w = (wn % 5 == 0) ? wlast : {$urandom, $urandom, $urandom, $urandom};
      wlast = w;
    end else begin
      w = wlast;  // identical data without valid must be ignored (R8)
    end
    bit_valid = v; bit_in = b; word_valid = wv; word_data = w;
    if (wv) begin
      e.rep = m_whave && (w == m_wprev);
      m_wprev = w; m_whave = 1;
    end
    if (v) begin
      if (m_sstart && int'(b) == m_sprev) begin
        m_slen++;
        e.lng   = (m_slen == 34);
        e.noise = (m_slen == 48);
      end else m_slen = 1;
      m_sprev = int'(b); m_sstart = 1;
      m_ones += int'(b);
      m_nib = m_nib * 2 + int'(b); m_ph++;
      if (m_ph == 4) begin m_pk[m_nib]++; m_nib = 0; m_ph = 0; end
      if (m_first) begin m_cur_bit = int'(b); m_cur_len = 1; m_first = 0; end
      else if (int'(b) == m_cur_bit) m_cur_len++;
      else begin record_run(m_cur_bit, m_cur_len); m_cur_bit = int'(b); m_cur_len = 1; end
      m_idx++;
      if (m_idx == BLK) begin
        record_run(m_cur_bit, m_cur_len);
        e.done = 1;
        e.mono = !(m_ones > 9654 && m_ones < 10346);
        sumsq = 0;
        for (int k = 0; k < 16; k++) sumsq += longint'(m_pk[k]) * m_pk[k];
        stat = 16 * sumsq - 64'd25000000;
        e.poker = !(stat > 5150 && stat < 287000);
        e.runs = 0;
        for (int k = 0; k < 6; k++)
          if (m_r0[k] < RLO[k] || m_r0[k] > RHI[k] || m_r1[k] < RLO[k] || m_r1[k] > RHI[k])
            e.runs = 1;
        m_idx = 0; m_ones = 0; m_nib = 0; m_ph = 0; m_first = 1;
        for (int k = 0; k < 16; k++) m_pk[k] = 0;
        for (int k = 0; k < 6; k++) begin m_r0[k] = 0; m_r1[k] = 0; end
      end
    end
    sb_q.push_back(e);
  endtask

  // monitor: compares outputs one cycle after each driven cycle
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk("R2 block_done", block_done, e.done);
        chk("R3 fail_monobit", fail_monobit, e.mono);
        chk("R4 fail_poker", fail_poker, e.poker);
        chk("R5 fail_runs", fail_runs, e.runs);
        chk("R6 fail_long_run", fail_long_run, e.lng);
        chk("R7 fail_noise", fail_noise, e.noise);
        chk("R8 fail_repeat", fail_repeat, e.rep);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog actual=%0d cycles expected=completion", WATCHDOG);
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) m_pk[k] = 0;
    for (int k = 0; k < 6; k++) begin m_r0[k] = 0; m_r1[k] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 block_done", block_done, 1'b0);
    chk("R1 fail_monobit", fail_monobit, 1'b0);
    chk("R1 fail_poker", fail_poker, 1'b0);
    chk("R1 fail_runs", fail_runs, 1'b0);
    chk("R1 fail_long_run", fail_long_run, 1'b0);
    chk("R1 fail_noise", fail_noise, 1'b0);
    chk("R1 fail_repeat", fail_repeat, 1'b0);

    // block A: pseudo-random with idle gaps (R2 ignored cycles)
    for (int i = 0; m_idx != 0 || i == 0; i++) begin
      if (i % 7 == 6) step(1'b0, ~bit_in);
      else step(1'b1, lfsr_bit());
    end
    // block B: alternating pattern (R4, R5 fail; R3 pass)
    for (int i = 0; i < BLK; i++) step(1'b1, i[0]);
    // block C: biased toward ones (R3), ending in 20 ones
    for (int i = 0; i < BLK - 20; i++) step(1'b1, lfsr_bit() | i[0]);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
    // block D: streak straddling the edge, exact 33 and 34 runs, long ones run (R6, R7)
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 33; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 34; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1);
    while (m_idx != 0) step(1'b1, lfsr_bit());
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    summary();
  end
endmodule